// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data byte into an asynchronous serial frame on a single TX line. A 7-bit control word picks the frame shape. It sets the data length (5 to 8 bits), the parity mode (none, odd, even, stuck at 1 or stuck at 0) and the stop length (1, 1.5 or 2 bit times). It also carries a break override that pulls the line low. Bit timing comes from an external one-cycle tick that pulses at 16 times the bit rate. The block does not divide the clock itself.

A byte enters through a valid/ready handshake and is accepted on a rising clock edge where both are high. The control word is captured at that same edge, so the software side can rewrite it while a frame is on the wire without corrupting that frame. The break bit is the exception: it acts on the line at once. The busy output covers the whole frame. The reset input is asynchronous and active low, and it is released synchronously inside the block.

Top module: `uart_frame_tx`

## Requirements
- R1: With no frame and no break, TX is 1. Each frame opens with a single start bit at 0, which appears on TX in the cycle after the accepting edge.
- R2: Control bits [1:0] set the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data goes out LSB first, and byte bits above the chosen length are never sent.
- R3: When control bit 3 is 0, the last data bit is followed directly by the stop bits, with no parity slot.
- R4: When control bit 3 is 1 and bit 5 is 0, bit 4 picks the parity. A 0 gives odd parity and a 1 gives even parity, taken over the sent data bits only.
- R5: When control bits 3 and 5 are both 1, the parity bit is fixed: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R6: When control bit 2 is 0 there is one stop bit. When it is 1, the stop time is 1.5 bits for 5-bit data and 2 bits for 6, 7 and 8-bit data. Stop bits are 1.
- R7: Start, data and parity bits each last exactly 16 baud ticks, and the extra half stop bit lasts 8. Clock cycles without a tick do not advance the frame.
- R8: While control bit 6 is 1, TX is 0 in the same cycle, whatever the frame state. When the bit clears, TX returns to what the frame or idle state calls for.
- R9: The control word is sampled at the accepting edge. Changes to bits [5:0] during a frame do not alter that frame.
- R10: Busy rises at the accepting edge and falls at the tick that ends the last stop bit. It is 0 at all other times.
- R11: Ready is 1 only when no frame is in progress, break is off and reset has been released. A byte is taken only at an edge where both valid and ready are 1.
- R12: During reset and for two edges after its release, TX is 1 (unless break is on), busy is 0 and ready is 0. A reset in mid-frame aborts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| ctrl_word | input | 7 | Frame format: [1:0] length, [2] stop, [3] parity on, [4] parity sense, [5] fixed parity, [6] break |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be accepted |
| tx_line | output | 1 | Serial output |
| tx_busy | output | 1 | Frame in progress |

## Verification
After the accepting edge, the start bit and busy are both due in the next cycle, because the sequencer state is the only register on the way. Every later bit boundary appears just after the edge that samples the 16th tick, or the 8th tick for a half stop bit. Ready and the break override are combinational from the control word, so they are due in the same cycle. The bench model keeps one queue entry per expected tick and pops it at exactly the edges where the design counts a tick. It then compares TX, busy and ready 5 ns after every rising edge, so every boundary is checked in the cycle it is due.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uft_rst_sync.sv
module uft_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/uft_fmt.sv
module uft_fmt #(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16,
  parameter int TKW    = $clog2(2*TICKS+1),
  parameter int LENW   = $clog2(DATA_W+1)
) (
  input  logic [5:0]        ctrl,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] data_m,
  output logic [LENW-1:0]   nbits,
  output logic              par_en,
  output logic              par_bit,
  output logic [TKW-1:0]    stop_ticks
);
  localparam int MIN_LEN = DATA_W - 3;
  localparam logic [TKW-1:0] STOP_ONE  = TKW'(TICKS);
  localparam logic [TKW-1:0] STOP_HALF = TKW'(TICKS + TICKS/2);
  localparam logic [TKW-1:0] STOP_TWO  = TKW'(2*TICKS);

  logic [1:0] len_sel;
  assign len_sel = ctrl[1:0];
  assign nbits   = LENW'(MIN_LEN) + LENW'(len_sel);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_LEN) begin : g_fixed
      assign data_m[i] = data[i];
    end else begin : g_opt
      localparam logic [1:0] SEL = 2'(i - MIN_LEN + 1);
      assign data_m[i] = data[i] & (len_sel >= SEL);
    end
  end

  assign par_en = ctrl[3];

  always_comb begin
    if (ctrl[5])      par_bit = ~ctrl[4];
    else if (ctrl[4]) par_bit = ^data_m;
    else              par_bit = ~(^data_m);
  end

  always_comb begin
    if (!ctrl[2])            stop_ticks = STOP_ONE;
    else if (len_sel == 2'b00) stop_ticks = STOP_HALF;
    else                     stop_ticks = STOP_TWO;
  end
endmodule

// File: rtl/uft_seq.sv
module uft_seq
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16,
  parameter int TKW    = $clog2(2*TICKS+1),
  parameter int LENW   = $clog2(DATA_W+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              accept,
  input  logic [DATA_W-1:0] data_m,
  input  logic [LENW-1:0]   nbits,
  input  logic              par_en,
  input  logic              par_bit,
  input  logic [TKW-1:0]    stop_ticks,
  output logic              line_bit,
  output logic              idle
);
  localparam logic [TKW-1:0] BIT_TICKS = TKW'(TICKS);

  tx_state_e         state_q, state_d;
  logic [TKW-1:0]    cnt_q, cnt_d;
  logic [LENW-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [LENW-1:0]   nbits_q;
  logic              par_en_q, par_q;
  logic [TKW-1:0]    stop_q;
  logic [TKW-1:0]    lim;
  logic              bit_end;

  assign lim     = (state_q == ST_STOP) ? stop_q : BIT_TICKS;
  assign bit_end = baud_tick && (cnt_q == lim - TKW'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    if (state_q == ST_IDLE) begin
      if (accept) begin
        state_d = ST_START;
        cnt_d   = '0;
        idx_d   = '0;
        shift_d = data_m;
      end
    end else if (baud_tick) begin
      cnt_d = bit_end ? '0 : cnt_q + TKW'(1);
      if (bit_end) begin
        case (state_q)
          ST_START: state_d = ST_DATA;
          ST_DATA: begin
            shift_d = {1'b0, shift_q[DATA_W-1:1]};
            if (idx_q == nbits_q - LENW'(1)) state_d = par_en_q ? ST_PAR : ST_STOP;
            else idx_d = idx_q + LENW'(1);
          end
          ST_PAR:  state_d = ST_STOP;
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits_q  <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      stop_q   <= BIT_TICKS;
    end else if (accept) begin
      nbits_q  <= nbits;
      par_en_q <= par_en;
      par_q    <= par_bit;
      stop_q   <= stop_ticks;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shift_q[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign idle = (state_q == ST_IDLE);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (cnt_q < lim)); // R7
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !baud_tick) |=> ($stable(state_q) && $stable(cnt_q))); // R7
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == ST_START && !line_bit)); // R1
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [6:0]        ctrl_word,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_line,
  output logic              tx_busy
);
  localparam int TKW  = $clog2(2*TICKS_PER_BIT+1);
  localparam int LENW = $clog2(DATA_W+1);

  logic              rst_i;
  logic [DATA_W-1:0] data_m;
  logic [LENW-1:0]   nbits;
  logic              par_en, par_bit;
  logic [TKW-1:0]    stop_ticks;
  logic              line_bit, idle;
  logic              brk, accept;

  uft_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i)
  );

  uft_fmt #(.DATA_W(DATA_W), .TICKS(TICKS_PER_BIT), .TKW(TKW), .LENW(LENW)) u_fmt (
    .ctrl       (ctrl_word[5:0]),
    .data       (tx_data),
    .data_m     (data_m),
    .nbits      (nbits),
    .par_en     (par_en),
    .par_bit    (par_bit),
    .stop_ticks (stop_ticks)
  );

  uft_seq #(.DATA_W(DATA_W), .TICKS(TICKS_PER_BIT), .TKW(TKW), .LENW(LENW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i),
    .baud_tick  (baud_tick),
    .accept     (accept),
    .data_m     (data_m),
    .nbits      (nbits),
    .par_en     (par_en),
    .par_bit    (par_bit),
    .stop_ticks (stop_ticks),
    .line_bit   (line_bit),
    .idle       (idle)
  );

  assign brk      = ctrl_word[6];
  assign tx_ready = rst_i && idle && !brk;
  assign accept   = tx_valid && tx_ready;
  assign tx_busy  = !idle;
  assign tx_line  = line_bit && !brk;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_i)
    tx_ready |-> tx_line); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_valid && tx_ready) |=> tx_busy); // R10
endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  localparam int DW  = 8;
  localparam int TPB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          baud_tick = 1'b0;
  logic          tx_valid = 1'b0;
  logic [6:0]    ctrl_word = '0;
  logic [DW-1:0] tx_data = '0;
  wire           tx_ready, tx_line, tx_busy;

  always #10 clk = ~clk;

  uart_frame_tx #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ctrl_word(ctrl_word),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_line(tx_line), .tx_busy(tx_busy)
  );

  typedef struct {
    bit    b;
    string tag;
  } ent_t;

  ent_t  q[$];
  int    checks = 0, fails = 0, acc_cnt = 0, rst_seen = 0;
  int    tick_div = 2, tick_ph = 0;
  bit    rdy_pre;
  bit    done = 0;
  string scen = "reset";

  task automatic push_bit(bit b, string tag, int n);
    ent_t e;
    e.b = b;
    e.tag = tag;
    repeat (n) q.push_back(e);
  endtask

  task automatic push_frame(logic [6:0] c, logic [7:0] d);
    int len, ones, n;
    bit p;
    len = 5 + int'(c[1:0]);
    ones = 0;
    push_bit(1'b0, "R1 R7", TPB);
    for (int i = 0; i < len; i++) begin
      push_bit(d[i], "R2 R7", TPB);
      ones += int'(d[i]);
    end
    if (c[3]) begin
      if (c[5])      p = !c[4];
      else if (c[4]) p = bit'(ones % 2);
      else           p = !bit'(ones % 2);
      push_bit(p, c[5] ? "R5" : "R4", TPB);
    end
    n = !c[2] ? TPB : ((len == 5) ? TPB + TPB/2 : 2*TPB);
    push_bit(1'b1, c[3] ? "R6" : "R3 R6", n);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      rst_seen = 0;
    end else begin
      if (rst_seen >= 2) begin
        rdy_pre = (q.size() == 0) && !ctrl_word[6];
        if (baud_tick && q.size() > 0) void'(q.pop_front());
        if (tx_valid && rdy_pre) begin
          push_frame(ctrl_word, tx_data);
          acc_cnt++;
        end
      end
      if (rst_seen < 2) rst_seen++;
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s [%s] actual=%0b expected=%0b at %0t", tag, what, scen, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (!done) begin
      logic e_tx, e_busy, e_rdy;
      string t;
      e_busy = (q.size() != 0);
      e_rdy  = (rst_seen >= 2) && !e_busy && !ctrl_word[6];
      if (ctrl_word[6])        begin e_tx = 1'b0; t = "R8"; end
      else if (e_busy)         begin e_tx = q[0].b; t = q[0].tag; end
      else if (rst_seen < 2)   begin e_tx = 1'b1; t = "R12"; end
      else                     begin e_tx = 1'b1; t = "R1"; end
      chk(t, tx_line, e_tx, "tx_line");
      chk((rst_seen < 2) ? "R12" : "R10", tx_busy, e_busy, "tx_busy");
      chk((rst_seen < 2) ? "R12" : "R11", tx_ready, e_rdy, "tx_ready");
    end
  end

  always @(negedge clk) begin
    if (tick_ph >= tick_div - 1) begin
      tick_ph = 0;
      baud_tick = 1'b1;
    end else begin
      tick_ph++;
      baud_tick = 1'b0;
    end
  end

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic send(logic [6:0] c, logic [7:0] d, bit idle_after);
    int s;
    @(negedge clk);
    ctrl_word = c;
    tx_data = d;
    tx_valid = 1'b1;
    s = acc_cnt;
    while (acc_cnt == s) @(negedge clk);
    tx_valid = 1'b0;
    if (idle_after) wait_idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired [%s] actual=running expected=finished", scen);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    scen = "R2 8-bit no parity";      send(7'h03, 8'hA5, 1);
    scen = "R6 5-bit 1.5 stop";       send(7'h04, 8'hFF, 1);
    tick_div = 3;
    scen = "R4 7-bit even";           send(7'h1A, 8'h5B, 1);
    scen = "R4 6-bit odd";            send(7'h09, 8'h2C, 1);
    scen = "R4 8-bit odd zero";       send(7'h0B, 8'h00, 1);
    scen = "R5 forced one";           send(7'h2B, 8'h81, 1);
    scen = "R5 forced zero";          send(7'h3B, 8'h7E, 1);
    scen = "R6 6-bit two stop";       send(7'h05, 8'h15, 1);
    scen = "R6 8-bit two stop";       send(7'h07, 8'hC3, 1);
    scen = "R3 7-bit no parity";      send(7'h02, 8'hF0, 1);
    tick_div = 1;
    scen = "R9 change mid frame";     send(7'h03, 8'h96, 0);
    repeat (40) @(negedge clk);
    ctrl_word = 7'h3C;
    wait_idle();
    scen = "R8 break while idle";
    @(negedge clk);
    ctrl_word = 7'h43;
    tx_data = 8'h55;
    tx_valid = 1'b1;
    repeat (30) @(negedge clk);
    ctrl_word = 7'h03;
    begin
      int s;
      s = acc_cnt;
      while (acc_cnt == s) @(negedge clk);
    end
    tx_valid = 1'b0;
    wait_idle();
    scen = "R8 break mid frame";      send(7'h03, 8'h3C, 0);
    repeat (50) @(negedge clk);
    ctrl_word = 7'h43;
    repeat (60) @(negedge clk);
    ctrl_word = 7'h03;
    wait_idle();
    scen = "R11 back to back";        send(7'h0B, 8'h11, 0);
    send(7'h1B, 8'h22, 0);
    wait_idle();
    scen = "R12 reset mid frame";     send(7'h03, 8'h7F, 0);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    scen = "R2 after reset";          send(7'h01, 8'hC9, 1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule